// File: doc/BRIEF.md
# PWM Output Compare Channel with Shadowed Compare Value

This block is one compare channel that sits beside a free-running 16-bit timer counter. Every clock it compares the counter value with an active compare register. On equality it raises a sticky match flag and drives its single waveform pin, according to a two-bit action code. The counter, its wrap logic and any interrupt routing live outside. The block receives the counter value and two single-cycle strobes that mark the counter's highest and lowest points.

The active compare value can be guarded by a shadow register, which avoids odd-length or lopsided PWM pulses. In the two PWM waveform modes, CPU writes land only in the shadow. The shadow is copied into the active register at one counter extreme, picked by the mode. In the two non-PWM modes, writes go straight to the active register. A software force strobe in the non-PWM modes moves the pin as a real match would. It leaves the flag alone.

CPU writes arrive on a valid/ready port. The port never applies back-pressure: ready is held high, and every cycle with valid high delivers one word. Only the CPU path ever changes the compare value.

Top module: `oc_unit`

## Requirements
- R1: During and right after reset, pin_out, match_flag and cmp_active are all 0.
- R2: In wave_mode 0 (normal) or 1 (clear on compare), an accepted write appears on cmp_active at the next clock edge.
- R3: In wave_mode 2 or 3 (PWM), an accepted write is held in the shadow register, and cmp_active does not change except at its mode's update event.
- R4: In wave_mode 2 the shadow is copied to cmp_active on a cycle with at_top high. In wave_mode 3 the copy happens on a cycle with at_bottom high. The strobe that belongs to the other PWM mode has no effect.
- R5: When cnt_val equals cmp_active, match_flag is 1 after the next edge. The flag then stays 1 until a cycle with flag_clr high and no match. A match in the same cycle as flag_clr keeps the flag set.
- R6: After a match, pin_out at the next edge follows out_mode: 00 holds the last level, 01 toggles, 10 drives 0, 11 drives 1.
- R7: In wave_mode 0 or 1, force_req applies the out_mode action to pin_out at the next edge and does not set match_flag. A force in the same cycle as a match applies the action once.
- R8: In wave_mode 2 or 3, force_req has no effect on pin_out.
- R9: wr_ready is always 1, so every cycle with wr_valid high transfers wr_data.
- R10: If a write and the mode's update event fall in the same cycle, cmp_active takes the shadow's previous content. The new word stays in the shadow until the next update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current timer counter value |
| at_top | input | 1 | Counter is at its highest point this cycle |
| at_bottom | input | 1 | Counter is at its lowest point this cycle |
| wave_mode | input | 2 | 0 normal, 1 clear on compare, 2 PWM update at top, 3 PWM update at bottom |
| out_mode | input | 2 | Pin action on match: 00 hold, 01 toggle, 10 clear, 11 set |
| force_req | input | 1 | Software force-match strobe |
| flag_clr | input | 1 | Write-one-to-clear for the match flag |
| wr_valid | input | 1 | CPU compare write valid |
| wr_ready | output | 1 | Always 1 |
| wr_data | input | 16 | CPU compare write value |
| pin_out | output | 1 | Waveform output pin |
| match_flag | output | 1 | Sticky match flag |
| cmp_active | output | 16 | Compare value currently in use |

## Verification
The bench aims at the cycle where a PWM-mode write meets its update strobe. A design that forwards the new word there would show it on cmp_active one event too early. It also tries the strobe of the other PWM mode, which a careless decoder would honour, and a force in a PWM mode, which a buggy design would let through to the pin. A match together with flag_clr catches a clear that wins over set. Force on a matching cycle catches a double toggle, and force with no match catches a flag set by the force.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL  = 2'd0,
    WM_CTC     = 2'd1,
    WM_PWM_TOP = 2'd2,
    WM_PWM_BOT = 2'd3
  } wave_mode_e;

  typedef enum logic [1:0] {
    OA_HOLD   = 2'd0,
    OA_TOGGLE = 2'd1,
    OA_CLEAR  = 2'd2,
    OA_SET    = 2'd3
  } out_act_e;

  // New pin level for a compare event under a given action code.
  function automatic logic pin_after(input out_act_e act, input logic cur);
    case (act)
      OA_TOGGLE: pin_after = ~cur;
      OA_CLEAR:  pin_after = 1'b0;
      OA_SET:    pin_after = 1'b1;
      default:   pin_after = cur;
    endcase
  endfunction

  function automatic logic is_pwm(input wave_mode_e m);
    is_pwm = (m == WM_PWM_TOP) || (m == WM_PWM_BOT);
  endfunction

endpackage

// File: rtl/oc_shadow.sv
module oc_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buffered,
  input  logic         upd_evt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cmp_q
);
  logic [W-1:0] shadow_q;

  // The shadow always captures writes, so it holds the latest CPU word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (wr_en) shadow_q <= wr_data;
  end

  // Active register: direct write when unbuffered, else copy at event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else if (!buffered) begin
      if (wr_en) cmp_q <= wr_data;
    end else if (upd_evt) begin
      cmp_q <= shadow_q;
    end
  end
endmodule

// File: rtl/oc_detect.sv
module oc_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         clr,
  output logic         hit,
  output logic         flag_q
);
  assign hit = (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/oc_wavegen.sv
module oc_wavegen
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       force_ok,
  input  out_act_e   act,
  output logic       pin_q
);
  logic evt;
  assign evt = hit | force_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else if (evt) pin_q <= pin_after(act, pin_q);
  end
endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import oc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_val,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic [1:0]   wave_mode,
  input  logic [1:0]   out_mode,
  input  logic         force_req,
  input  logic         flag_clr,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  output logic         pin_out,
  output logic         match_flag,
  output logic [W-1:0] cmp_active
);
  wave_mode_e wm;
  out_act_e   oa;
  logic       buffered, upd_evt, wr_en, force_ok, hit;

  assign wm       = wave_mode_e'(wave_mode);
  assign oa       = out_act_e'(out_mode);
  assign buffered = is_pwm(wm);
  assign upd_evt  = ((wm == WM_PWM_TOP) && at_top) ||
                    ((wm == WM_PWM_BOT) && at_bottom);
  assign wr_ready = 1'b1;
  assign wr_en    = wr_valid && wr_ready;
  assign force_ok = force_req && !buffered;

  oc_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .buffered(buffered), .upd_evt(upd_evt),
    .wr_en(wr_en), .wr_data(wr_data), .cmp_q(cmp_active)
  );

  oc_detect #(.W(W)) u_detect (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_val), .cmp(cmp_active),
    .clr(flag_clr), .hit(hit), .flag_q(match_flag)
  );

  oc_wavegen u_wave (
    .clk(clk), .rst_n(rst_n), .hit(hit), .force_ok(force_ok),
    .act(oa), .pin_q(pin_out)
  );
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt_val,
  input logic         at_top,
  input logic         at_bottom,
  input logic [1:0]   wave_mode,
  input logic         force_req,
  input logic         flag_clr,
  input logic         wr_valid,
  input logic         wr_ready,
  input logic [W-1:0] wr_data,
  input logic         pin_out,
  input logic         match_flag,
  input logic [W-1:0] cmp_active
);
  logic pwm_evt;
  assign pwm_evt = (wave_mode == 2'd2 && at_top) || (wave_mode == 2'd3 && at_bottom);

  // R1: outputs held at zero while reset is applied
  always @(posedge clk)
    if (!rst_n) a_r1_reset_zero: assert (!pin_out && !match_flag && cmp_active == '0);

  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wave_mode[1]) |=> (cmp_active == $past(wr_data)));

  a_r3_pwm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode[1] && !pwm_evt) |=> $stable(cmp_active));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val == cmp_active) |=> match_flag);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag);

  a_r7_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && !match_flag && cnt_val != cmp_active) |=> !match_flag);

  a_r8_pwm_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode[1] && cnt_val != cmp_active) |=> $stable(pin_out));

  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);
endmodule

bind oc_unit oc_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .at_top(at_top),
  .at_bottom(at_bottom), .wave_mode(wave_mode), .force_req(force_req),
  .flag_clr(flag_clr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .pin_out(pin_out), .match_flag(match_flag),
  .cmp_active(cmp_active)
);

// File: tb/sim_oc_unit.sv
`timescale 1ns/1ps
module sim_oc_unit;
  localparam int W = 16;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0, wr_data = '0;
  logic at_top = 0, at_bottom = 0, force_req = 0, flag_clr = 0, wr_valid = 0;
  logic [1:0] wave_mode = 0, out_mode = 0;
  logic wr_ready, pin_out, match_flag;
  logic [W-1:0] cmp_active;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [W-1:0] m_buf = '0, m_act = '0;
  logic m_pin = 0, m_flag = 0;

  always #HALF clk = ~clk;

  oc_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .at_top(at_top),
    .at_bottom(at_bottom), .wave_mode(wave_mode), .out_mode(out_mode),
    .force_req(force_req), .flag_clr(flag_clr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .pin_out(pin_out),
    .match_flag(match_flag), .cmp_active(cmp_active)
  );

  function automatic logic act_pin(input logic [1:0] om, input logic cur);
    case (om)
      2'b01: return ~cur;
      2'b10: return 1'b0;
      2'b11: return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Advance the model with the inputs currently driven, clock once, sample at negedge.
  task automatic step();
    logic pwm, evt, match;
    pwm   = wave_mode[1];
    evt   = (wave_mode == 2'd2 && at_top) || (wave_mode == 2'd3 && at_bottom);
    match = (cnt_val == m_act);
    if (match || (force_req && !pwm)) m_pin = act_pin(out_mode, m_pin);
    if (match) m_flag = 1'b1; else if (flag_clr) m_flag = 1'b0;
    if (!pwm) begin if (wr_valid) m_act = wr_data; end
    else if (evt) m_act = m_buf;
    if (wr_valid) m_buf = wr_data;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    at_top = 0; at_bottom = 0; force_req = 0; flag_clr = 0; wr_valid = 0;
    cnt_val = 16'hFFFF;
  endtask

  initial begin
    #(2*HALF*200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk);
    chk("R1 pin", {15'd0, pin_out}, 16'd0);
    chk("R1 flag", {15'd0, match_flag}, 16'd0);
    chk("R1 cmp", cmp_active, 16'd0);
    rst_n = 1;
    chk("R9 ready", {15'd0, wr_ready}, 16'd1);

    // R2 direct write in normal mode
    wave_mode = 0; wr_valid = 1; wr_data = 16'h1234; step(); idle();
    chk("R2 direct", cmp_active, 16'h1234);

    // R3 / R4 buffered, update at top
    wave_mode = 2; wr_valid = 1; wr_data = 16'h0055; step(); idle();
    chk("R3 held", cmp_active, 16'h1234);
    at_bottom = 1; step(); idle();
    chk("R4 wrong strobe", cmp_active, 16'h1234);
    at_top = 1; step(); idle();
    chk("R4 top copy", cmp_active, 16'h0055);

    // R10 write coinciding with bottom event
    wave_mode = 3; wr_valid = 1; wr_data = 16'h0066; step(); idle();
    at_top = 1; step(); idle();
    chk("R4 top ignored in mode 3", cmp_active, 16'h0055);
    wr_valid = 1; wr_data = 16'h0077; at_bottom = 1; step(); idle();
    chk("R10 old shadow", cmp_active, 16'h0066);
    at_bottom = 1; step(); idle();
    chk("R10 new later", cmp_active, 16'h0077);

    // R6 pin actions on a real match
    wave_mode = 0; wr_valid = 1; wr_data = 16'd5; step(); idle();
    out_mode = 2'b11; cnt_val = 16'd5; step(); idle();
    chk("R6 set", {15'd0, pin_out}, 16'd1);
    chk("R5 flag set", {15'd0, match_flag}, 16'd1);
    out_mode = 2'b10; cnt_val = 16'd5; step(); idle();
    chk("R6 clear", {15'd0, pin_out}, 16'd0);
    out_mode = 2'b01; cnt_val = 16'd5; step(); idle();
    chk("R6 toggle", {15'd0, pin_out}, 16'd1);
    out_mode = 2'b00; cnt_val = 16'd5; step(); idle();
    chk("R6 hold", {15'd0, pin_out}, 16'd1);
    step();
    chk("R5 sticky", {15'd0, match_flag}, 16'd1);
    flag_clr = 1; cnt_val = 16'd5; step(); idle();
    chk("R5 set beats clear", {15'd0, match_flag}, 16'd1);
    flag_clr = 1; step(); idle();
    chk("R5 cleared", {15'd0, match_flag}, 16'd0);

    // R7 force in CTC mode, no match
    wave_mode = 1; out_mode = 2'b10; force_req = 1; step(); idle();
    chk("R7 force pin", {15'd0, pin_out}, 16'd0);
    chk("R7 force no flag", {15'd0, match_flag}, 16'd0);
    out_mode = 2'b01; force_req = 1; cnt_val = 16'd5; step(); idle();
    chk("R7 force+match once", {15'd0, pin_out}, 16'd1);
    flag_clr = 1; step(); idle();

    // R8 force ignored in PWM mode
    wave_mode = 2; out_mode = 2'b01; force_req = 1; step(); idle();
    chk("R8 pwm force", {15'd0, pin_out}, 16'd1);
    chk("R8 pwm force flag", {15'd0, match_flag}, 16'd0);

    // constrained random against the bench model
    for (int i = 0; i < 4000; i++) begin
      wave_mode = 2'($urandom_range(0, 3));
      out_mode  = 2'($urandom_range(0, 3));
      at_top    = ($urandom_range(0, 3) == 0);
      at_bottom = ($urandom_range(0, 3) == 0);
      force_req = ($urandom_range(0, 7) == 0);
      flag_clr  = ($urandom_range(0, 5) == 0);
      wr_valid  = ($urandom_range(0, 3) == 0);
      wr_data   = 16'($urandom_range(0, 7));
      cnt_val   = 16'($urandom_range(0, 7));
      step();
      chk("R6 rand pin", {15'd0, pin_out}, {15'd0, m_pin});
      chk("R5 rand flag", {15'd0, match_flag}, {15'd0, m_flag});
      chk("R3 rand cmp", cmp_active, m_act);
    end
    idle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule